// File: doc/BRIEF.md
# Converter Serial Readout Sequencer

This block is the device side of a serial port on a sampling converter that makes its own serial clock. A conversion engine hands a finished result word to the block through a valid/ready handshake. The block holds that word and shows "result ready" by driving the data line low while the serial clock rests high. When the host pulls the select line low, the block starts toggling the clock, at a rate set by dividing the system clock. It shifts the result out MSB first and captures a configuration word from the host's data line on the same clock.

A readout ends in one of two ways: after the last rising clock edge, or at once if the host raises select partway through. Either way the block returns to busy and pulses a start-conversion output for one cycle. It then decides whether the configuration captured so far is committed. A partial word is dropped. A complete word that changes the channel field is kept only if select stayed low for one more falling clock edge.

Back-pressure: `conv_ready` is high only while the block is busy and has no result waiting. A result transfers on a cycle where `conv_valid` and `conv_ready` are both high. While `conv_ready` is low the source must hold its word and valid, and nothing it offers has any effect.

Top module: `conv_readout_seq`

## Requirements
- R1: During and after reset the block is busy: `sdo` high, `sck` high, `conv_ready` high, `start_conv` low, and `cfg` equal to parameter `CFG_DEFAULT`.
- R2: `conv_ready` is high exactly in the busy state. A word transfers when `conv_valid` and `conv_ready` are both high, and on the next cycle `sdo` goes low with `sck` still high. A `conv_valid` offered while `conv_ready` is low changes nothing.
- R3: In the ready state, a low `cs_n` sampled at a clock edge drives `sck` low at that edge. `sck` then alternates, each level lasting `DIV_HALF` clock cycles, until the 32nd high level ends or the readout is aborted. A high `cs_n` in the ready state leaves the block waiting.
- R4: `sdo` changes only on falling `sck` edges during a readout. After the n-th falling edge (n = 1..32), `sdo` carries result bit 32-n, so bit 31 goes out first.
- R5: When the 32nd high `sck` level ends, `sdo` goes high, `sck` stays high, the block is busy again, and `start_conv` is high for exactly one cycle.
- R6: `cs_n` sampled high during a readout ends it at that clock edge. `sck` and `sdo` go high, the block is busy, and `start_conv` pulses for one cycle.
- R7: On each of the first 13 rising `sck` edges, `sdi` is sampled into the configuration shift register, MSB first. `sdi` is read on the system clock edge that drives `sck` high.
- R8: After a full 32-bit readout the 13 captured bits become `cfg`.
- R9: An abort before the 13th rising edge leaves `cfg` unchanged.
- R10: An abort after the 13th rising edge but before the 14th falling edge commits the captured word only if its channel field (`cfg[12:8]`, the top `CH_W` bits) equals that of the current `cfg`.
- R11: An abort after the 14th falling edge commits the captured word.
- R12: `cfg` changes only in a cycle where `start_conv` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cs_n | input | 1 | Active-low select from the host |
| sdi | input | 1 | Configuration bits from the host |
| conv_valid | input | 1 | Result word offered by the conversion engine |
| conv_ready | output | 1 | Block can accept a result (busy state) |
| conv_data | input | 32 | Result word |
| sck | output | 1 | Internally generated serial clock |
| sdo | output | 1 | Serial result out; high when busy, low when ready |
| start_conv | output | 1 | One-cycle pulse that starts a new conversion |
| cfg | output | 13 | Committed configuration word |

## Verification
Full readouts are run with two alternating result patterns, once keeping the channel field and once changing it. These show that the bit order and the full-length commit are right. Aborts are placed before the first rising edge, after one rising edge, before the 13th rise, exactly at the 13th rise with and without a channel change, and after the 14th fall. Together they separate the discard, conditional-commit and commit windows. One run keeps `conv_valid` high through a readout and holds `cs_n` high in the ready state for a while, to show that back-pressure and the wait for select hold.

// File: rtl/conv_rd_pkg.sv
package conv_rd_pkg;
  typedef enum logic [1:0] {
    ST_BUSY  = 2'd0,
    ST_READY = 2'd1,
    ST_SHIFT = 2'd2
  } rd_state_e;
endpackage

// File: rtl/crs_phase_gen.sv
module crs_phase_gen #(
  parameter int W        = 32,
  parameter int DIV_HALF = 2,
  localparam int SW      = (DIV_HALF > 1) ? $clog2(DIV_HALF) : 1,
  localparam int HW      = $clog2(2 * W),
  localparam int RCW     = $clog2(2 * W + 1)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           begin_i,
  input  logic           run_i,
  output logic           rise_o,
  output logic           fall_o,
  output logic           last_o,
  output logic [RCW-1:0] rises_o,
  output logic [RCW-1:0] falls_o
);
  logic [SW-1:0] sub_q;
  logic [HW-1:0] half_q;
  logic          tick;
  logic          at_end;

  assign tick   = run_i && (sub_q == SW'(DIV_HALF - 1));
  assign at_end = (half_q == HW'(2 * W - 1));
  assign rise_o = tick && !half_q[0];
  assign fall_o = tick && half_q[0] && !at_end;
  assign last_o = tick && at_end;

  assign rises_o = RCW'(half_q[HW-1:1]) + RCW'(half_q[0]);
  assign falls_o = RCW'(half_q[HW-1:1]) + RCW'(1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sub_q  <= '0;
      half_q <= '0;
    end else if (begin_i) begin
      sub_q  <= '0;
      half_q <= '0;
    end else if (run_i) begin
      if (tick) begin
        sub_q <= '0;
        if (!at_end) half_q <= half_q + HW'(1);
      end else begin
        sub_q <= sub_q + SW'(1);
      end
    end
  end
endmodule

// File: rtl/crs_tx.sv
module crs_tx #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         accept_i,
  input  logic [W-1:0] data_i,
  input  logic         begin_i,
  input  logic         fall_i,
  input  logic         finish_i,
  output logic         sdo_o
);
  logic [W-1:0] word_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      word_q <= '0;
      sdo_o  <= 1'b1;
    end else if (finish_i) begin
      sdo_o <= 1'b1;
    end else if (accept_i) begin
      word_q <= data_i;
      sdo_o  <= 1'b0;
    end else if (begin_i || fall_i) begin
      sdo_o  <= word_q[W-1];
      word_q <= {word_q[W-2:0], 1'b0};
    end
  end
endmodule

// File: rtl/crs_cfg_rx.sv
module crs_cfg_rx #(
  parameter int              CFG_W       = 13,
  parameter int              CH_W        = 5,
  parameter int              RCW         = 7,
  parameter logic [CFG_W-1:0] CFG_DEFAULT = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rise_i,
  input  logic [RCW-1:0]   rises_i,
  input  logic [RCW-1:0]   falls_i,
  input  logic             sdi_i,
  input  logic             finish_i,
  output logic [CFG_W-1:0] cfg_o
);
  logic [CFG_W-1:0] shreg_q;
  logic             full_word;
  logic             same_ch;
  logic             past_guard;
  logic             commit;

  assign full_word  = (rises_i >= RCW'(CFG_W));
  assign same_ch    = (shreg_q[CFG_W-1 -: CH_W] == cfg_o[CFG_W-1 -: CH_W]);
  assign past_guard = (falls_i >= RCW'(CFG_W + 1));
  assign commit     = finish_i && full_word && (same_ch || past_guard);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      shreg_q <= '0;
      cfg_o   <= CFG_DEFAULT;
    end else begin
      if (rise_i && (rises_i < RCW'(CFG_W)))
        shreg_q <= {shreg_q[CFG_W-2:0], sdi_i};
      if (commit)
        cfg_o <= shreg_q;
    end
  end
endmodule

// File: rtl/conv_readout_seq.sv
module conv_readout_seq #(
  parameter int               W           = 32,
  parameter int               DIV_HALF    = 2,
  parameter int               CFG_W       = 13,
  parameter int               CH_W        = 5,
  parameter logic [CFG_W-1:0] CFG_DEFAULT = '0,
  localparam int              RCW         = $clog2(2 * W + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cs_n,
  input  logic             sdi,
  input  logic             conv_valid,
  output logic             conv_ready,
  input  logic [W-1:0]     conv_data,
  output logic             sck,
  output logic             sdo,
  output logic             start_conv,
  output logic [CFG_W-1:0] cfg
);
  import conv_rd_pkg::*;

  rd_state_e      st_q;
  logic           accept;
  logic           begin_rd;
  logic           run;
  logic           abort;
  logic           finish;
  logic           rise_ev;
  logic           fall_ev;
  logic           last_ev;
  logic [RCW-1:0] rises;
  logic [RCW-1:0] falls;

  assign conv_ready = (st_q == ST_BUSY);
  assign accept     = conv_ready && conv_valid;
  assign begin_rd   = (st_q == ST_READY) && !cs_n;
  assign run        = (st_q == ST_SHIFT) && !cs_n;
  assign abort      = (st_q == ST_SHIFT) && cs_n;
  assign finish     = abort || last_ev;

  crs_phase_gen #(.W(W), .DIV_HALF(DIV_HALF)) u_phase (
    .clk     (clk),
    .rst_n   (rst_n),
    .begin_i (begin_rd),
    .run_i   (run),
    .rise_o  (rise_ev),
    .fall_o  (fall_ev),
    .last_o  (last_ev),
    .rises_o (rises),
    .falls_o (falls)
  );

  crs_tx #(.W(W)) u_tx (
    .clk      (clk),
    .rst_n    (rst_n),
    .accept_i (accept),
    .data_i   (conv_data),
    .begin_i  (begin_rd),
    .fall_i   (fall_ev),
    .finish_i (finish),
    .sdo_o    (sdo)
  );

  crs_cfg_rx #(.CFG_W(CFG_W), .CH_W(CH_W), .RCW(RCW),
               .CFG_DEFAULT(CFG_DEFAULT)) u_rx (
    .clk      (clk),
    .rst_n    (rst_n),
    .rise_i   (rise_ev),
    .rises_i  (rises),
    .falls_i  (falls),
    .sdi_i    (sdi),
    .finish_i (finish),
    .cfg_o    (cfg)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q       <= ST_BUSY;
      sck        <= 1'b1;
      start_conv <= 1'b0;
    end else begin
      start_conv <= 1'b0;
      unique case (st_q)
        ST_BUSY:  if (accept) st_q <= ST_READY;
        ST_READY: if (begin_rd) begin
                    st_q <= ST_SHIFT;
                    sck  <= 1'b0;
                  end
        ST_SHIFT: begin
                    if (finish) begin
                      st_q       <= ST_BUSY;
                      sck        <= 1'b1;
                      start_conv <= 1'b1;
                    end else if (rise_ev) begin
                      sck <= 1'b1;
                    end else if (fall_ev) begin
                      sck <= 1'b0;
                    end
                  end
        default:  st_q <= ST_BUSY;
      endcase
    end
  end
endmodule

// File: rtl/crs_checker.sv
module crs_checker #(
  parameter int CFG_W = 13
) (
  input logic             clk,
  input logic             rst_n,
  input logic             sck,
  input logic             sdo,
  input logic             start_conv,
  input logic             conv_ready,
  input logic [CFG_W-1:0] cfg
);
  AST_BUSY_SCK_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    conv_ready |-> sck) else $error("busy with sck low"); // R3

  AST_START_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    start_conv |=> !start_conv) else $error("start pulse too long"); // R5

  AST_START_IDLE_LINES: assert property (@(posedge clk) disable iff (!rst_n)
    start_conv |-> (sdo && sck && conv_ready)) else $error("lines not idle at start"); // R6

  AST_SDO_HOLD_ON_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(sck) && !start_conv) |-> $stable(sdo)) else $error("sdo moved on rising sck"); // R4

  AST_CFG_WITH_START: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(cfg) |-> start_conv) else $error("cfg changed without start"); // R12
endmodule

bind conv_readout_seq crs_checker #(.CFG_W(CFG_W)) u_crs_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .sck        (sck),
  .sdo        (sdo),
  .start_conv (start_conv),
  .conv_ready (conv_ready),
  .cfg        (cfg)
);

// File: tb/conv_readout_seq_bench.sv
module conv_readout_seq_bench;
  localparam int CLK_PERIOD = 10;
  localparam int DIVH       = 3;
  localparam logic [12:0] CFG_DEF = 13'h0A5;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cs_n = 1'b1;
  logic        sdi = 1'b0;
  logic        conv_valid = 1'b0;
  logic [31:0] conv_data = '0;
  logic        conv_ready, sck, sdo, start_conv;
  logic [12:0] cfg;

  int n_checks = 0;
  int n_fail   = 0;
  bit finished = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  conv_readout_seq #(.DIV_HALF(DIVH), .CFG_DEFAULT(CFG_DEF)) u_conv_readout_seq (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sdi(sdi),
    .conv_valid(conv_valid), .conv_ready(conv_ready), .conv_data(conv_data),
    .sck(sck), .sdo(sdo), .start_conv(start_conv), .cfg(cfg));

  // behavioural reference: integer phase counting, no shared structure
  int          m_st, m_sub, m_rises, m_falls;
  int          m_shreg, m_cfg;
  logic [31:0] m_word;
  logic        m_sck, m_sdo, m_start;

  task automatic m_finish();
    if (m_rises >= 13 && (((m_shreg >> 8) & 31) == ((m_cfg >> 8) & 31) || m_falls >= 14))
      m_cfg = m_shreg;
    m_sck = 1; m_sdo = 1; m_start = 1; m_st = 0;
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      m_st = 0; m_sck = 1; m_sdo = 1; m_start = 0; m_cfg = int'(CFG_DEF);
      m_shreg = 0; m_rises = 0; m_falls = 0; m_sub = 0;
    end else begin
      m_start = 0;
      if (m_st == 0) begin
        if (conv_valid) begin m_word = conv_data; m_sdo = 0; m_st = 1; end
      end else if (m_st == 1) begin
        if (!cs_n) begin
          m_st = 2; m_sub = 0; m_rises = 0; m_falls = 1; m_sck = 0; m_sdo = m_word[31];
        end
      end else begin
        if (cs_n) m_finish();
        else if (m_sub == DIVH - 1) begin
          m_sub = 0;
          if (m_sck == 0) begin
            m_sck = 1; m_rises++;
            if (m_rises <= 13) m_shreg = ((m_shreg << 1) | int'(sdi)) & 13'h1FFF;
          end else if (m_rises == 32) m_finish();
          else begin
            m_sck = 0; m_falls++; m_sdo = m_word[32 - m_falls];
          end
        end else m_sub++;
      end
    end
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !finished) begin
      check(sck == m_sck, "R3 sck", sck, m_sck);
      check(sdo == m_sdo, "R4 sdo", sdo, m_sdo);
      check(start_conv == m_start, "R5 start_conv", start_conv, m_start);
      check(conv_ready == (m_st == 0), "R2 conv_ready", conv_ready, m_st == 0);
      check(int'(cfg) == m_cfg, "R12 cfg", cfg, m_cfg);
    end
  end

  // offer a result, run one readout, abort once rises>=ar and falls>=af
  task automatic readout(input logic [31:0] data, input logic [12:0] cw,
                         input int ar, input int af, input bit hold_valid,
                         input int wait_cs);
    @(negedge clk);
    conv_valid = 1'b1; conv_data = data;
    do @(negedge clk); while (m_st == 0);
    if (!hold_valid) conv_valid = 1'b0;
    conv_data = ~data;
    repeat (wait_cs) @(negedge clk);
    cs_n = 1'b0;
    do begin
      @(negedge clk);
      sdi = (m_st == 2 && m_rises < 13) ? cw[12 - m_rises] : 1'b0;
      if (m_st == 2 && m_rises >= ar && m_falls >= af) cs_n = 1'b1;
    end while (m_st != 0);
    cs_n = 1'b1;
    conv_valid = 1'b0;
    check(sdo && sck, "R6 lines idle after readout", {sdo, sck}, 2'b11);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(sdo && sck && conv_ready && !start_conv, "R1 reset lines",
          {sdo, sck, conv_ready, start_conv}, 4'b1110);
    check(cfg == CFG_DEF, "R1 reset cfg", cfg, CFG_DEF);
    rst_n = 1'b1;
    // full readout, channel changes: R7 R8
    readout(32'h5AC3_0F96, 13'h1B2D, 99, 99, 0, 0);
    check(cfg == 13'h1B2D, "R7/R8 full readout cfg", cfg, 13'h1B2D);
    // full readout, other pattern, with cs_n held high in ready and valid held (R2 R3)
    readout(32'hA53C_F069, 13'h1B11, 99, 99, 1, 7);
    check(cfg == 13'h1B11, "R8 second full readout", cfg, 13'h1B11);
    // abort before 13th rise: R9
    readout(32'h1234_5678, 13'h0777, 5, 0, 0, 0);
    check(cfg == 13'h1B11, "R9 early abort keeps cfg", cfg, 13'h1B11);
    // abort at once after first fall: R6 R9
    readout(32'hFFFF_0000, 13'h0001, 0, 1, 0, 0);
    check(cfg == 13'h1B11, "R9 immediate abort keeps cfg", cfg, 13'h1B11);
    readout(32'h8000_0001, 13'h0002, 1, 0, 0, 0);
    check(cfg == 13'h1B11, "R9 abort after one rise", cfg, 13'h1B11);
    // 13th rise, channel change: R10 discard
    readout(32'hDEAD_BEEF, 13'h04C4, 13, 0, 0, 0);
    check(cfg == 13'h1B11, "R10 channel change discarded", cfg, 13'h1B11);
    // 13th rise, same channel: R10 commit
    readout(32'hCAFE_F00D, 13'h1BEE, 13, 0, 0, 0);
    check(cfg == 13'h1BEE, "R10 same channel committed", cfg, 13'h1BEE);
    // after 14th fall, channel change: R11
    readout(32'h0F0F_3C3C, 13'h0321, 13, 14, 0, 0);
    check(cfg == 13'h0321, "R11 late abort committed", cfg, 13'h0321);
    finished = 1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    if (!finished) begin
      finished = 1;
      n_checks++; n_fail++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end
endmodule